// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This unit holds a bank of hardware token flags that two independent ports, left and right, share in order to take turns at exclusive use of a common resource. Each port selects one flag with a small address and performs single-cycle accesses. An access reaches the semaphore bank only when the port's memory select is inactive and its semaphore select is active. A write with data bit 0 low asks for the token and a write with bit 0 high gives it back (or withdraws a request that has not been granted).

A request that arrives while the other port holds the token is not lost. It is remembered inside the flag and becomes ownership on the cycle the holder releases, so the losing side never has to retry. A read returns the token state as the reading port sees it: all zeros when this port holds the token, all ones otherwise. Accesses are plain single-cycle strobes with no back-pressure. A read answer appears with a one-cycle valid pulse, and no ready signal exists because the unit always accepts.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free and no request is pending. Both read-valid outputs are low until a read is issued.
- R2: An access is performed only when `*_sem_sel` is 1 and `*_mem_sel` is 0. Any other combination leaves every flag unchanged and raises no read-valid.
- R3: `*_addr` selects one of NSEM independent flags. An access changes only the flag it addresses.
- R4: A write with bit 0 = 0 to a free flag grants the token to the writer. A read then returns all DW bits 0 to the holder and all DW bits 1 to the other port.
- R5: A write with bit 0 = 0 to a flag the other port holds leaves the owner unchanged, so the writer still reads all ones. The request is recorded as pending.
- R6: When the holder writes bit 0 = 1 and the other port has a pending request, the token moves to that port in the same update. The new holder reads 0 and the former holder reads 1.
- R7: When the holder writes bit 0 = 1 and nothing is pending, the flag becomes free and both ports read all ones.
- R8: When both ports write bit 0 = 0 to the same free flag in the same cycle, the left port is granted and the right port's request becomes pending.
- R9: A pending requester that writes bit 0 = 1 before it is granted withdraws its request. A later release then frees the flag.
- R10: Only bit 0 of `*_wdata` is used on a write. All other bits are ignored.
- R11: A read access drives `*_rvalid` high for one cycle after the access edge, together with `*_rdata`. The data reflects the flag state before any write in the same cycle.
- R12: A holder that requests again, or a port that releases a flag it neither holds nor waits on, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_mem_sel | input | 1 | Left memory select, must be 0 for semaphore access |
| l_sem_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | AW | Left flag index |
| l_wdata | input | DW | Left write data, bit 0 used |
| l_rdata | output | DW | Left read data, replicated token view |
| l_rvalid | output | 1 | Left read data valid |
| r_mem_sel | input | 1 | Right memory select, must be 0 for semaphore access |
| r_sem_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | AW | Right flag index |
| r_wdata | input | DW | Right write data, bit 0 used |
| r_rdata | output | DW | Right read data, replicated token view |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The embedded properties watch each flag on every cycle. They check that a holder keeps its token until it releases, that a release hands over to a pending requester or frees the flag, that a same-cycle tie goes to the left, that a withdrawal clears the pending mark, and that the pending mark never exists on a free flag. They also check that read-valid follows a read strobe by one cycle with uniform data. Only the bench scenarios show the port-level views: which port reads 0 after each sequence, the gating by the two selects, flag independence, the ignored upper data bits, and read-before-write ordering within a cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NSEM = 8,
  localparam int AW = $clog2(NSEM)
) (
  input  logic            mem_sel,
  input  logic            sem_sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic            wbit,
  output logic [NSEM-1:0] req,
  output logic [NSEM-1:0] rel,
  output logic            rd_stb
);
  logic acc;
  assign acc    = sem_sel & ~mem_sel;
  assign rd_stb = acc & ~wr;

  for (genvar i = 0; i < NSEM; i++) begin : g_sel
    logic hit;
    assign hit    = acc & wr & (addr == AW'(i));
    assign req[i] = hit & ~wbit;
    assign rel[i] = hit &  wbit;
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_own,
  output logic r_own
);
  owner_e own_q, own_d;
  logic   pend_q, pend_d;
  logic   p_tmp;

  always_comb begin
    own_d  = own_q;
    pend_d = pend_q;
    p_tmp  = pend_q;
    unique case (own_q)
      OWN_NONE: begin
        if (l_req) begin
          own_d  = OWN_LEFT;
          pend_d = r_req;
        end else if (r_req) begin
          own_d  = OWN_RIGHT;
          pend_d = 1'b0;
        end
      end
      OWN_LEFT: begin
        p_tmp = r_req ? 1'b1 : (r_rel ? 1'b0 : pend_q);
        if (l_rel) begin
          own_d  = p_tmp ? OWN_RIGHT : OWN_NONE;
          pend_d = 1'b0;
        end else begin
          pend_d = p_tmp;
        end
      end
      OWN_RIGHT: begin
        p_tmp = l_req ? 1'b1 : (l_rel ? 1'b0 : pend_q);
        if (r_rel) begin
          own_d  = p_tmp ? OWN_LEFT : OWN_NONE;
          pend_d = 1'b0;
        end else begin
          pend_d = p_tmp;
        end
      end
      default: begin
        own_d  = OWN_NONE;
        pend_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= OWN_NONE;
      pend_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      pend_q <= pend_d;
    end
  end

  assign l_own = (own_q == OWN_LEFT);
  assign r_own = (own_q == OWN_RIGHT);

  // R5: a pending mark only exists while someone holds the token
  p_pend_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (own_q != OWN_NONE));

  // R4: free flag plus left request gives left ownership
  p_grant_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE) && l_req |=> (own_q == OWN_LEFT));

  // R5: the other port cannot take a held token
  p_hold_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT) && !l_rel |=> (own_q == OWN_LEFT));
  p_hold_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_RIGHT) && !r_rel |=> (own_q == OWN_RIGHT));

  // R6: release with a pending request hands over
  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT) && l_rel && pend_q && !r_rel |=> (own_q == OWN_RIGHT));

  // R7: release with nothing pending frees the flag
  p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_RIGHT) && r_rel && !pend_q && !l_req |=> (own_q == OWN_NONE) && !pend_q);

  // R8: tie on a free flag goes to left, right pending
  p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE) && l_req && r_req |=> (own_q == OWN_LEFT) && pend_q);

  // R9: withdrawal clears the pending mark
  p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT) && pend_q && r_rel && !r_req && !l_rel |=> !pend_q);
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int NSEM = 8,
  parameter int DW   = 18,
  localparam int AW  = $clog2(NSEM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [AW-1:0]   addr,
  input  logic [NSEM-1:0] own_vec,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '1;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_stb;
      if (rd_stb) rdata <= {DW{~own_vec[addr]}};
    end
  end

  // R11: valid follows a read strobe by exactly one cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rvalid);
  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rvalid);
  // R4: returned data is uniform across all bits
  p_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($countones(rdata) == 0 || $countones(rdata) == DW));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int DW   = 18,
  localparam int AW  = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_mem_sel,
  input  logic          l_sem_sel,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          r_mem_sel,
  input  logic          r_sem_sel,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid
);
  logic [NSEM-1:0] l_req, l_rel, r_req, r_rel, l_own, r_own;
  logic            l_rd, r_rd;

  sem_port_decode #(.NSEM(NSEM)) u_dec_l (
    .mem_sel(l_mem_sel), .sem_sel(l_sem_sel), .wr(l_wr), .addr(l_addr),
    .wbit(l_wdata[0]), .req(l_req), .rel(l_rel), .rd_stb(l_rd));

  sem_port_decode #(.NSEM(NSEM)) u_dec_r (
    .mem_sel(r_mem_sel), .sem_sel(r_sem_sel), .wr(r_wr), .addr(r_addr),
    .wbit(r_wdata[0]), .req(r_req), .rel(r_rel), .rd_stb(r_rd));

  for (genvar i = 0; i < NSEM; i++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .l_own(l_own[i]), .r_own(r_own[i]));
  end

  sem_readback #(.NSEM(NSEM), .DW(DW)) u_rb_l (
    .clk(clk), .rst_n(rst_n), .rd_stb(l_rd), .addr(l_addr),
    .own_vec(l_own), .rdata(l_rdata), .rvalid(l_rvalid));

  sem_readback #(.NSEM(NSEM), .DW(DW)) u_rb_r (
    .clk(clk), .rst_n(rst_n), .rd_stb(r_rd), .addr(r_addr),
    .own_vec(r_own), .rdata(r_rdata), .rvalid(r_rvalid));

  // R4: a token is never seen as held by both ports
  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_rvalid && r_rvalid && (l_rdata[0] == 1'b0) && (r_rdata[0] == 1'b0)
      && $past(l_addr) == $past(r_addr)));
endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
  localparam int NSEM = 8;
  localparam int DW   = 18;
  localparam int AW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_mem_sel, l_sem_sel, l_wr, r_mem_sel, r_sem_sel, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sem_bank #(.NSEM(NSEM), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_mem_sel(l_mem_sel), .l_sem_sel(l_sem_sel), .l_wr(l_wr), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_mem_sel(r_mem_sel), .r_sem_sel(r_sem_sel), .r_wr(r_wr), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid));

  // ops: 0 idle, 1 write, 2 read, 3 write with memory select active (blocked)
  // fields: lop[17:16] la[15:13] ld[12] rop[11:10] ra[9:7] rd[6] le[5] re[4] tag[3:0]
  localparam int VN = 32;
  localparam logic [17:0] VEC [0:VN-1] = '{
    {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b1, 4'd1},  // R1 reset view
    {2'd1,3'd0,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd4},  // R4 left takes s0
    {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b0,1'b1, 4'd4},
    {2'd0,3'd0,1'b0, 2'd1,3'd0,1'b0, 1'b0,1'b0, 4'd5},  // R5 right loses, pending
    {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b0,1'b1, 4'd5},
    {2'd1,3'd0,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd6},  // R6 hand over
    {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b0, 4'd6},
    {2'd0,3'd0,1'b0, 2'd1,3'd0,1'b1, 1'b0,1'b0, 4'd7},  // R7 free
    {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b1, 4'd7},
    {2'd1,3'd3,1'b0, 2'd1,3'd3,1'b0, 1'b0,1'b0, 4'd8},  // R8 tie
    {2'd2,3'd3,1'b0, 2'd2,3'd3,1'b0, 1'b0,1'b1, 4'd8},
    {2'd1,3'd3,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd8},
    {2'd2,3'd3,1'b0, 2'd2,3'd3,1'b0, 1'b1,1'b0, 4'd8},
    {2'd1,3'd3,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd9},  // R9 left pending
    {2'd1,3'd3,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd9},  // R9 withdraw
    {2'd0,3'd0,1'b0, 2'd1,3'd3,1'b1, 1'b0,1'b0, 4'd9},
    {2'd2,3'd3,1'b0, 2'd2,3'd3,1'b0, 1'b1,1'b1, 4'd9},
    {2'd3,3'd5,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd2},  // R2 blocked write
    {2'd2,3'd5,1'b0, 2'd2,3'd5,1'b0, 1'b1,1'b1, 4'd2},
    {2'd1,3'd5,1'b0, 2'd1,3'd6,1'b0, 1'b0,1'b0, 4'd3},  // R3 two flags
    {2'd2,3'd5,1'b0, 2'd2,3'd6,1'b0, 1'b0,1'b0, 4'd3},
    {2'd2,3'd6,1'b0, 2'd2,3'd5,1'b0, 1'b1,1'b1, 4'd3},
    {2'd1,3'd5,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd12}, // R12 holder asks again
    {2'd2,3'd5,1'b0, 2'd2,3'd5,1'b0, 1'b0,1'b1, 4'd12},
    {2'd1,3'd5,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd10}, // R10 upper bits 0
    {2'd2,3'd5,1'b0, 2'd2,3'd5,1'b0, 1'b1,1'b1, 4'd12},
    {2'd0,3'd0,1'b0, 2'd1,3'd5,1'b1, 1'b0,1'b0, 4'd12}, // R12 release of free
    {2'd2,3'd5,1'b0, 2'd2,3'd5,1'b0, 1'b1,1'b1, 4'd12},
    {2'd1,3'd1,1'b0, 2'd1,3'd1,1'b0, 1'b0,1'b0, 4'd11},
    {2'd1,3'd1,1'b1, 2'd2,3'd1,1'b0, 1'b0,1'b1, 4'd11}, // R11 read sees old state
    {2'd2,3'd1,1'b0, 2'd2,3'd1,1'b0, 1'b1,1'b0, 4'd11},
    {2'd0,3'd0,1'b0, 2'd2,3'd6,1'b0, 1'b0,1'b0, 4'd3}
  };

  task automatic check(input int tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R10: write data carries the inverse of bit 0 in every upper bit
  task automatic drive_l(input logic [1:0] op, input logic [AW-1:0] a, input logic b);
    l_sem_sel = (op != 2'd0);
    l_mem_sel = (op == 2'd3);
    l_wr      = (op == 2'd1) || (op == 2'd3);
    l_addr    = a;
    l_wdata   = {{(DW-1){~b}}, b};
  endtask

  task automatic drive_r(input logic [1:0] op, input logic [AW-1:0] a, input logic b);
    r_sem_sel = (op != 2'd0);
    r_mem_sel = (op == 2'd3);
    r_wr      = (op == 2'd1) || (op == 2'd3);
    r_addr    = a;
    r_wdata   = {{(DW-1){~b}}, b};
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive_l(2'd0, '0, 1'b0);
    drive_r(2'd0, '0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1, "l_rvalid after reset", DW'(l_rvalid), '0);  // R1
    check(1, "r_rvalid after reset", DW'(r_rvalid), '0);

    for (int i = 0; i < VN; i++) begin
      logic [17:0] v;
      v = VEC[i];
      drive_l(v[17:16], v[15:13], v[12]);
      drive_r(v[11:10], v[9:7], v[6]);
      step();
      check(int'(v[3:0]), $sformatf("l_rvalid vec %0d", i), DW'(l_rvalid), DW'(v[17:16] == 2'd2));
      check(int'(v[3:0]), $sformatf("r_rvalid vec %0d", i), DW'(r_rvalid), DW'(v[11:10] == 2'd2));
      if (v[17:16] == 2'd2)
        check(int'(v[3:0]), $sformatf("l_rdata vec %0d", i), l_rdata, {DW{v[5]}});
      if (v[11:10] == 2'd2)
        check(int'(v[3:0]), $sformatf("r_rdata vec %0d", i), r_rdata, {DW{v[4]}});
    end

    // R2: read with memory select active produces no valid
    drive_l(2'd0, '0, 1'b0);
    drive_r(2'd0, '0, 1'b0);
    l_sem_sel = 1'b1; l_mem_sel = 1'b1; l_wr = 1'b0; l_addr = 3'd0;
    step();
    check(2, "blocked read valid", DW'(l_rvalid), '0);

    // R2: write with semaphore select inactive is ignored
    l_sem_sel = 1'b0; l_mem_sel = 1'b0; l_wr = 1'b1; l_addr = 3'd7; l_wdata = '0;
    step();
    drive_l(2'd2, 3'd7, 1'b0);
    drive_r(2'd2, 3'd7, 1'b0);
    step();
    check(2, "unselected write left view", l_rdata, '1);
    check(2, "unselected write right view", r_rdata, '1);

    // R1: reset mid-run clears holders and pending requests
    drive_l(2'd1, 3'd2, 1'b0);
    drive_r(2'd1, 3'd2, 1'b0);
    step();
    drive_l(2'd0, '0, 1'b0);
    drive_r(2'd0, '0, 1'b0);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check(1, "rvalid low after reset", DW'(l_rvalid | r_rvalid), '0);
    drive_l(2'd2, 3'd2, 1'b0);
    drive_r(2'd2, 3'd2, 1'b0);
    step();
    check(1, "left view after reset", l_rdata, '1);
    check(1, "right view after reset", r_rdata, '1);
    drive_l(2'd1, 3'd2, 1'b1);
    drive_r(2'd0, '0, 1'b0);
    step();
    drive_l(2'd0, '0, 1'b0);
    drive_r(2'd2, 3'd2, 1'b0);
    step();
    check(1, "no stale pending after reset", r_rdata, '1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule